// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a small programmable logic array: a bank of eight identical macrocells sitting between an external sum-of-products array and the device pins. Each cell receives one sum term and one output-enable product term from the array. It can turn them into a clocked output, a combinatorial output with a programmable or fixed enable, or leave its pin undriven so that the pin works as an input. Every pin is modelled as a driven value plus a drive enable. An external level input stands in for whatever drives the pin when the cell does not, and the resolved pin level is what the bank treats as "the pin".

A two-bit global mode selects one of three operating styles. In the registered style, the clock input and the active-low common enable input play their dedicated roles. Clocked cells load their terms and feed the register state back to the array. In the complex style, the two dedicated pins become plain array inputs, and only the inner cells feed the pin level back to the array. The simple style drops the programmable enables altogether. A synchronous active-low reset stands in for power-up clearing, so that clocked outputs come up high.

Cell `i` is configured by a 3-bit field `cell_cfg[3*i +: 3]`. Bits [1:0] hold the role: 00 clocked, 01 combinatorial I/O, 10 combinatorial output, 11 dedicated input. Bit 2 is the polarity bit. The global mode encodes 00 registered, 01 complex, and 10 or 11 simple.

Top module: `pld_macrocell_bank`

## Requirements
- R1: On a rising clock edge with `rst_n` low, every cell register clears to 0. A clocked cell in registered mode then shows a high `pin_out` and feeds back 0, even if its term would have loaded a 1 in that cycle.
- R2: A clocked cell (role 00) in registered mode loads its term on each rising edge with `rst_n` high. After that edge it drives the inverted register value on `pin_out` and feeds the register value back on `fb_out`.
- R3: When polarity bit 2 of a cell is 1, the sum term is inverted before it reaches the register or the pin. When bit 2 is 0, the sum term passes unchanged.
- R4: In registered mode, every clocked cell has `pin_oe` equal to the inverse of `pin11_n`. The enable is shared by all clocked cells and takes effect without waiting for a clock edge.
- R5: A combinatorial I/O cell (role 01) in registered or complex mode drives the term on `pin_out` combinationally and takes `pin_oe` from its own `oe_term` bit.
- R6: A combinatorial output cell (role 10) always has `pin_oe` = 1. The same holds for a clocked-role cell (role 00) in complex or simple mode.
- R7: A dedicated input cell (role 11) never drives its pin (`pin_oe` = 0) in any mode. Its `fb_out` follows `pin_ext`, except at the two end cells in complex mode.
- R8: In simple mode (encoding 10 or 11), a combinatorial I/O cell has `pin_oe` = 1 whatever its `oe_term`.
- R9: A cell register loads only in registered mode with role 00. Otherwise it holds its value, which shows again as soon as the cell returns to the clocked role in registered mode.
- R10: In registered mode, a non-clocked cell feeds back its resolved pin level: `pin_out` when `pin_oe` is 1, `pin_ext` otherwise.
- R11: In complex mode, cells 1 to 6 feed back their resolved pin level, while cells 0 and 7 feed back a constant 0.
- R12: In simple mode, every cell feeds back its resolved pin level.
- R13: `aux_in` is 00 in registered mode. In the other modes it equals `{pin11_n, pin1_lvl}`, passing the two dedicated pins to the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for the cell registers (pin 1 in registered mode) |
| rst_n | input | 1 | Synchronous active-low reset, stands in for power-up clear |
| glob_mode | input | 2 | Global mode: 00 registered, 01 complex, 10/11 simple |
| cell_cfg | input | 24 | Per-cell field: bit 2 polarity, bits 1:0 role |
| sum_in | input | 8 | Sum term for each cell from the array |
| oe_term | input | 8 | Output-enable product term for each cell |
| pin1_lvl | input | 1 | Level of the clock pin when it is used as a plain input |
| pin11_n | input | 1 | Active-low common enable in registered mode, plain input otherwise |
| pin_ext | input | 8 | Level that external logic places on each pin when the cell does not drive it |
| pin_out | output | 8 | Value each cell drives toward its pin |
| pin_oe | output | 8 | Drive enable for each pin |
| fb_out | output | 8 | Feedback from each cell to the array |
| aux_in | output | 2 | The two dedicated pins as array inputs |

## Verification
Two events can fall on the same clock edge: a reset and a term load in a clocked cell. The bench holds a term that would load ones while it keeps `rst_n` low across an edge. It then expects all-high outputs and zero feedback, not the loaded value. On the following edge with reset released, it expects the loaded value. A second overlap is also tested: changing the shared enable or the mode between edges must change the drive and routing at once, while the register keeps its contents.

// File: rtl/pld_mc_pkg.sv
// Package: shared encodings for the macrocell bank.
// Assumes the two-bit mode and role encodings listed in the brief.
package pld_mc_pkg;

    typedef enum logic [1:0] {
        MODE_REG      = 2'd0,
        MODE_CPLX     = 2'd1,
        MODE_SIMP     = 2'd2,
        MODE_SIMP_ALT = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ROLE_REG  = 2'd0,
        ROLE_CIO  = 2'd1,
        ROLE_COUT = 2'd2,
        ROLE_DIN  = 2'd3
    } role_e;

    typedef struct packed {
        logic  invert;
        role_e role;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    // True for both encodings of the simple style.
    function automatic logic is_simple(mode_e m);
        return (m == MODE_SIMP) || (m == MODE_SIMP_ALT);
    endfunction

endpackage

// File: rtl/pld_mc_cell.sv
// Module: one output macrocell.
// Holds a single register, applies polarity, and picks the pin value
// and drive enable from the role and the global mode.
// Assumes: synchronous active-low reset; reg_oe is already active-high.
module pld_mc_cell
    import pld_mc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  mode_e     mode,
    input  cell_cfg_t cfg,
    input  logic      sum_term,
    input  logic      oe_term,
    input  logic      reg_oe,
    input  logic      pin_ext,
    output logic      pin_out,
    output logic      pin_oe,
    output logic      pin_lvl,
    output logic      q_out
);

    logic term;
    logic q;
    logic load;

    assign term = sum_term ^ cfg.invert;
    assign load = (mode == MODE_REG) && (cfg.role == ROLE_REG);

    // Register: clears on reset, loads the term only when clocked role is live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (load) begin
            q <= term;
        end
    end

    // Output select: pin value and drive enable per role and mode.
    always_comb begin
        pin_out = term;
        pin_oe  = 1'b1;
        if (load) begin
            pin_out = ~q;
            pin_oe  = reg_oe;
        end else begin
            case (cfg.role)
                ROLE_DIN: pin_oe = 1'b0;
                ROLE_CIO: pin_oe = is_simple(mode) ? 1'b1 : oe_term;
                default:  pin_oe = 1'b1;
            endcase
        end
    end

    assign pin_lvl = pin_oe ? pin_out : pin_ext;
    assign q_out   = q;

endmodule

// File: rtl/pld_mc_fb_route.sv
// Module: feedback selection for all cells.
// Registered mode feeds back the register of clocked cells and the
// pin level of the others. Complex mode blanks the two end cells.
// Simple mode feeds back every pin level.
// Assumes NCELL >= 2.
module pld_mc_fb_route
    import pld_mc_pkg::*;
#(
    parameter int NCELL = 8
) (
    input  mode_e              mode,
    input  logic [NCELL-1:0]   reg_sel,
    input  logic [NCELL-1:0]   q,
    input  logic [NCELL-1:0]   lvl,
    output logic [NCELL-1:0]   fb
);

    localparam int LAST = NCELL - 1;

    for (genvar i = 0; i < NCELL; i++) begin : g_fb
        localparam bit END_CELL = (i == 0) || (i == LAST);
        logic cplx_fb;
        // Per-cell route: end cells have no pin path in complex mode.
        assign cplx_fb = END_CELL ? 1'b0 : lvl[i];
        assign fb[i] = (mode == MODE_REG)  ? (reg_sel[i] ? q[i] : lvl[i]) :
                       (mode == MODE_CPLX) ? cplx_fb : lvl[i];
    end

endmodule

// File: rtl/pld_macrocell_bank.sv
// Module: top of the configurable macrocell bank.
// Instantiates NCELL cells and the feedback router. It also routes the
// two dedicated pins to the array outside registered mode.
// Assumes: clk is the dedicated clock pin and pin11_n is active-low.
module pld_macrocell_bank
    import pld_mc_pkg::*;
#(
    parameter int NCELL = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              glob_mode,
    input  logic [NCELL*CFG_W-1:0]  cell_cfg,
    input  logic [NCELL-1:0]        sum_in,
    input  logic [NCELL-1:0]        oe_term,
    input  logic                    pin1_lvl,
    input  logic                    pin11_n,
    input  logic [NCELL-1:0]        pin_ext,
    output logic [NCELL-1:0]        pin_out,
    output logic [NCELL-1:0]        pin_oe,
    output logic [NCELL-1:0]        fb_out,
    output logic [1:0]              aux_in
);

    mode_e            mode;
    logic [NCELL-1:0] reg_q;
    logic [NCELL-1:0] pin_lvl;
    logic [NCELL-1:0] reg_sel;

    assign mode = mode_e'(glob_mode);

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        cell_cfg_t cfg_i;
        assign cfg_i      = cell_cfg_t'(cell_cfg[i*CFG_W +: CFG_W]);
        assign reg_sel[i] = (cfg_i.role == ROLE_REG);

        pld_mc_cell i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode),
            .cfg      (cfg_i),
            .sum_term (sum_in[i]),
            .oe_term  (oe_term[i]),
            .reg_oe   (~pin11_n),
            .pin_ext  (pin_ext[i]),
            .pin_out  (pin_out[i]),
            .pin_oe   (pin_oe[i]),
            .pin_lvl  (pin_lvl[i]),
            .q_out    (reg_q[i])
        );
    end

    pld_mc_fb_route #(.NCELL(NCELL)) i_fb (
        .mode    (mode),
        .reg_sel (reg_sel),
        .q       (reg_q),
        .lvl     (pin_lvl),
        .fb      (fb_out)
    );

    // Dedicated pins reach the array only when they are not clock and enable.
    assign aux_in = (mode == MODE_REG) ? 2'b00 : {pin11_n, pin1_lvl};

endmodule

// File: rtl/pld_mc_checker.sv
// Module: temporal checks for the macrocell bank, attached by bind.
// Assumes the encodings of the brief; reg_q is the bank's register vector.
module pld_mc_checker #(
    parameter int NCELL = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         glob_mode,
    input logic [NCELL*3-1:0] cell_cfg,
    input logic [NCELL-1:0]   sum_in,
    input logic               pin11_n,
    input logic [NCELL-1:0]   pin_out,
    input logic [NCELL-1:0]   pin_oe,
    input logic [NCELL-1:0]   fb_out,
    input logic [1:0]         aux_in,
    input logic [NCELL-1:0]   reg_q
);

    // R1: the first cycle out of reset sees cleared registers.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_q == '0));

    // R11: end cells give no feedback in complex mode.
    assert_end_fb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_mode == 2'd1) |-> (fb_out[0] == 1'b0 && fb_out[NCELL-1] == 1'b0));

    // R13: dedicated pins are withheld from the array in registered mode.
    assert_aux_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_mode == 2'd0) |-> (aux_in == 2'b00));

    for (genvar i = 0; i < NCELL; i++) begin : g_chk
        logic [1:0] role;
        logic       inv;
        assign role = cell_cfg[3*i +: 2];
        assign inv  = cell_cfg[3*i + 2];

        // R2: a clocked cell shows the inverse of the term loaded at the last edge.
        assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(glob_mode) == 2'd0 && $past(role) == 2'd0 &&
             glob_mode == 2'd0 && role == 2'd0)
            |-> (pin_out[i] == ~($past(sum_in[i]) ^ $past(inv))));

        // R4: shared enable drives all clocked cells.
        assert_reg_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (glob_mode == 2'd0 && role == 2'd0) |-> (pin_oe[i] == !pin11_n));

        // R6: combinatorial output always drives.
        assert_cout_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (role == 2'd2) |-> pin_oe[i]);

        // R7: dedicated input never drives.
        assert_din_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (role == 2'd3) |-> !pin_oe[i]);

        // R9: the register holds unless the clocked role is live.
        assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !($past(glob_mode) == 2'd0 && $past(role) == 2'd0))
            |-> $stable(reg_q[i]));
    end

endmodule

bind pld_macrocell_bank pld_mc_checker #(.NCELL(NCELL)) i_pld_mc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob_mode (glob_mode),
    .cell_cfg  (cell_cfg),
    .sum_in    (sum_in),
    .pin11_n   (pin11_n),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .fb_out    (fb_out),
    .aux_in    (aux_in),
    .reg_q     (reg_q)
);

// File: tb/test_pld_macrocell_bank.sv
// Bench: table of combinatorial vectors, then directed tests of the
// clocked path, reset, enable, hold and dedicated pins.
module test_pld_macrocell_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  glob_mode;
    logic [23:0] cell_cfg;
    logic [7:0]  sum_in, oe_term, pin_ext;
    logic        pin1_lvl, pin11_n;
    logic [7:0]  pin_out, pin_oe, fb_out;
    logic [1:0]  aux_in;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pld_macrocell_bank i_pld_macrocell_bank (
        .clk(clk), .rst_n(rst_n), .glob_mode(glob_mode), .cell_cfg(cell_cfg),
        .sum_in(sum_in), .oe_term(oe_term), .pin1_lvl(pin1_lvl), .pin11_n(pin11_n),
        .pin_ext(pin_ext), .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out),
        .aux_in(aux_in)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [23:0] cfg;
        logic [7:0]  sum;
        logic [7:0]  oet;
        logic [7:0]  ext;
        logic [7:0]  e_out;
        logic [7:0]  e_oe;
        logic [7:0]  e_fb;
    } vec_t;

    // Config in octal: one digit per cell, cell 0 rightmost, digit = {polarity, role}.
    localparam vec_t VEC [6] = '{
        // R5 R11: complex mode, I/O cells with programmable enable
        '{2'd1, 24'o11111111, 8'hA5, 8'h0F, 8'h3C, 8'hA5, 8'h0F, 8'h34},
        // R8 R3 R12: simple mode, inverted I/O cells all driving
        '{2'd2, 24'o55555555, 8'h0F, 8'h00, 8'hFF, 8'hF0, 8'hFF, 8'hF0},
        // R7 R11: complex mode, dedicated inputs
        '{2'd1, 24'o33333333, 8'hFF, 8'hFF, 8'h99, 8'hFF, 8'h00, 8'h18},
        // R6 R12: simple mode, combinatorial outputs
        '{2'd2, 24'o22222222, 8'h3C, 8'h00, 8'h00, 8'h3C, 8'hFF, 8'h3C},
        // R5 R10: registered mode, no clocked cells
        '{2'd0, 24'o11111111, 8'h81, 8'hF0, 8'h0F, 8'h81, 8'hF0, 8'h8F},
        // R6 R7 R8 R12: alternate simple encoding, mixed roles
        '{2'd3, 24'o01230123, 8'h55, 8'h00, 8'hAA, 8'h55, 8'hEE, 8'h44}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edge_settle();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; glob_mode = 2'd0; cell_cfg = 24'o00000000;
        sum_in = 8'hFF; oe_term = 8'h00; pin_ext = 8'h00;
        pin1_lvl = 1'b0; pin11_n = 1'b0;
        edge_settle();
        edge_settle();
        // R1: outputs high, zero feedback after reset
        chk("R1 reset out", pin_out, 8'hFF);
        chk("R1 reset fb", fb_out, 8'h00);
        chk("R4 reset oe", pin_oe, 8'hFF);
        rst_n = 1'b1;

        for (int k = 0; k < 6; k++) begin
            glob_mode = VEC[k].mode; cell_cfg = VEC[k].cfg; sum_in = VEC[k].sum;
            oe_term = VEC[k].oet; pin_ext = VEC[k].ext;
            #1;
            chk($sformatf("R5-table v%0d out", k), pin_out, VEC[k].e_out);
            chk($sformatf("R6-table v%0d oe", k), pin_oe, VEC[k].e_oe);
            chk($sformatf("R10-table v%0d fb", k), fb_out, VEC[k].e_fb);
            edge_settle();
        end

        // Restore registers to a known state: reset overlapping a load (R1).
        glob_mode = 2'd0; cell_cfg = 24'o00000000; sum_in = 8'h5A; pin11_n = 1'b0;
        pin_ext = 8'h00; oe_term = 8'h00; rst_n = 1'b0;
        edge_settle();
        chk("R1 reset beats load out", pin_out, 8'hFF);
        chk("R1 reset beats load fb", fb_out, 8'h00);
        rst_n = 1'b1;
        edge_settle();
        chk("R2 load after reset out", pin_out, 8'hA5);
        chk("R2 load after reset fb", fb_out, 8'h5A);

        // R2 R10: plain load
        sum_in = 8'h3C;
        edge_settle();
        chk("R2 load out", pin_out, 8'hC3);
        chk("R2 load fb", fb_out, 8'h3C);

        // R3: polarity before the register
        cell_cfg = 24'o44444444;
        edge_settle();
        chk("R3 inverted load out", pin_out, 8'h3C);
        chk("R3 inverted load fb", fb_out, 8'hC3);

        // R4: common enable off, no edge needed
        pin11_n = 1'b1;
        #1;
        chk("R4 enable off oe", pin_oe, 8'h00);
        chk("R4 enable off out", pin_out, 8'h3C);
        pin11_n = 1'b0;

        // R9 R6 R11: complex mode, clocked role acts combinatorial, register holds
        glob_mode = 2'd1; cell_cfg = 24'o00000000; sum_in = 8'hFF;
        edge_settle();
        edge_settle();
        chk("R6 complex clocked-role out", pin_out, 8'hFF);
        chk("R6 complex clocked-role oe", pin_oe, 8'hFF);
        chk("R11 complex fb", fb_out, 8'h7E);
        // R13: dedicated pins reach the array
        pin1_lvl = 1'b1;
        #1;
        chk("R13 aux complex", {6'd0, aux_in}, 8'h01);
        glob_mode = 2'd0; sum_in = 8'h00;
        #1;
        chk("R9 held register out", pin_out, 8'h3C);
        chk("R9 held register fb", fb_out, 8'hC3);
        chk("R13 aux registered", {6'd0, aux_in}, 8'h00);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule